// File: doc/BRIEF.md
# Embedded-Clock Frame Aligner

This block sits behind a clock-and-data recovery front end. It takes the recovered serial stream one bit per clock cycle and finds the frame boundary. Each 28-bit frame carries a 24-bit payload, a parity bit, a balance bit and two fixed marker bits that form the embedded clock edge. The block needs no training sequence: it tries each candidate bit offset in turn. It accepts an offset only after a run of consecutive frames shows the marker pair and correct parity at that offset.

Once locked, the block turns every frame into a 24-bit word with a one-cycle strobe. It re-inverts the payload when the balance bit says the payload was sent inverted. A single bad frame, whether from a missing marker or a parity failure, drops lock at once. Search then restarts without any outside action.

Output enables stand in for tri-state pads. The data outputs are enabled only while the block is locked and the receiver is enabled. The lock flag stays visible unless power-down is asserted. Power-down clears all tracking state.

Top module: `frame_aligner`

## Requirements
- R1: During and right after reset, lockOut, dataOe and wordValid are 0 and dataOut is all zeros; lockOe is 1 while pwrDnN is high.
- R2: A frame is 28 bits in arrival order: bit 0 is marker 1, bits 1..24 are payload bits 0..23, bit 25 is parity, bit 26 is balance, and bit 27 is marker 0. A frame is good when bit 0 is 1, bit 27 is 0, and the XOR of bits 1..26 is 0.
- R3: Lock is reached on arbitrary payload data with no training pattern. After each rejected candidate, the candidate offset moves by one bit.
- R4: An offset is accepted only after ACQ_FRAMES (default 4) consecutive good frames. lockOut therefore stays low for at least (ACQ_FRAMES-1)*28 cycles after reset or after leaving power-down.
- R5: When the balance bit is 1, dataOut is the bitwise inverse of the received payload bits, which restores the original word.
- R6: While locked, each good frame produces exactly one word. wordValid is a one-cycle pulse two cycles after the cycle in which the frame's last bit is presented.
- R7: lockOut rises in the same cycle as the first wordValid pulse.
- R8: A frame with a missing marker while locked drives lockOut low in the cycle its word would have appeared, and no word is output for it.
- R9: A frame that fails parity while locked drops lock in the same way as R8.
- R10: After losing lock, the block searches again and relocks without any outside action.
- R11: While lockOut is low, dataOe and wordValid are 0 and dataOut is all zeros.
- R12: While rxEn is low, dataOe and wordValid are 0 and dataOut is all zeros, and lockOut keeps reporting the lock state.
- R13: While pwrDnN is low, lockOe, lockOut and dataOe are 0. Tracking state is cleared, so a full acquisition (R4) is needed afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrDnN | input | 1 | Active-low power-down |
| rxEn | input | 1 | Receiver output enable |
| serIn | input | 1 | Serial bit in |
| lockOut | output | 1 | Frame lock flag |
| lockOe | output | 1 | Output enable of the lock flag |
| dataOut | output | PAYLOAD_W | Restored payload word |
| dataOe | output | 1 | Output enable of the data and strobe |
| wordValid | output | 1 | One-cycle strobe per delivered word |

## Verification
The properties assume that rxEn, pwrDnN and serIn are synchronous to clk and settle between edges. The bench meets this by changing all inputs right after the falling edge. The exact-latency checks also assume that no misaligned offset can pass four frames in a row. Random data could occasionally imitate the markers and parity, so the stimulus sends an all-zero payload every fourth frame. Such a frame has only one 1-to-0 marker pair, at the true boundary, which rules out a false lock while the payload stays random elsewhere.

// File: rtl/fal_pkg.sv
package fal_pkg;

  // Strobes passed from the control FSM to the datapath
  typedef struct packed {
    logic shiftEn;   // shift one serial bit into the window
    logic clearWin;  // clear window and output word (power-down)
    logic loadWord;  // capture the restored payload of the current window
  } falStrobes_t;

  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_LOCKED = 1'b1
  } falState_e;

endpackage

// File: rtl/fal_datapath.sv
module fal_datapath
  import fal_pkg::*;
#(
  parameter int PAYLOAD_W = 24
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 serIn,
  input  falStrobes_t          strb,
  output logic                 frameOk,
  output logic [PAYLOAD_W-1:0] wordOut
);

  localparam int FRAME_W = PAYLOAD_W + 4;
  localparam int PAR_POS = PAYLOAD_W + 1;
  localparam int BAL_POS = PAYLOAD_W + 2;
  localparam int END_POS = FRAME_W - 1;

  // win[0] is the oldest bit, win[END_POS] the newest
  logic [FRAME_W-1:0]   win;
  logic [PAYLOAD_W-1:0] restored;
  logic                 markerOk;
  logic                 parityOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      win <= '0;
    end else if (strb.clearWin) begin
      win <= '0;
    end else if (strb.shiftEn) begin
      win <= {serIn, win[FRAME_W-1:1]};
    end
  end

  // Marker pair at both ends; even parity over payload, parity and balance
  assign markerOk = win[0] & ~win[END_POS];
  assign parityOk = ~(^win[BAL_POS:1]);
  assign frameOk  = markerOk & parityOk;

  // Undo the per-frame inversion flagged by the balance bit
  for (genvar gi = 0; gi < PAYLOAD_W; gi++) begin : g_restore
    assign restored[gi] = win[gi+1] ^ win[BAL_POS];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordOut <= '0;
    end else if (strb.clearWin) begin
      wordOut <= '0;
    end else if (strb.loadWord) begin
      wordOut <= restored;
    end
  end

  // Parity position is covered by the XOR range above
  localparam int UNUSED_PAR = PAR_POS;

endmodule

// File: rtl/fal_control.sv
module fal_control
  import fal_pkg::*;
#(
  parameter int FRAME_W    = 28,
  parameter int ACQ_FRAMES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pwrDnN,
  input  logic        frameOk,
  output falStrobes_t strb,
  output logic        lockFlag,
  output logic        wordStrobe
);

  localparam int PH_W  = $clog2(FRAME_W);
  localparam int CNT_W = $clog2(ACQ_FRAMES + 1);

  falState_e        state;
  logic [PH_W-1:0]  phase;
  logic [CNT_W-1:0] goodCnt;
  logic             checkNow;
  logic             lastAcq;
  logic             accept;

  assign checkNow = (phase == PH_W'(FRAME_W - 1));
  assign lastAcq  = (goodCnt == CNT_W'(ACQ_FRAMES - 1));
  assign accept   = checkNow & frameOk & ((state == ST_LOCKED) | lastAcq);

  always_comb begin
    strb.shiftEn  = pwrDnN;
    strb.clearWin = ~pwrDnN;
    strb.loadWord = accept;
  end

  assign lockFlag = (state == ST_LOCKED);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_SEARCH;
      phase      <= '0;
      goodCnt    <= '0;
      wordStrobe <= 1'b0;
    end else if (!pwrDnN) begin
      state      <= ST_SEARCH;
      phase      <= '0;
      goodCnt    <= '0;
      wordStrobe <= 1'b0;
    end else begin
      wordStrobe <= accept;
      if (!checkNow) begin
        phase <= phase + PH_W'(1);
      end else if (frameOk) begin
        phase <= '0;
        if (state == ST_SEARCH) begin
          if (lastAcq) begin
            state   <= ST_LOCKED;
            goodCnt <= '0;
          end else begin
            goodCnt <= goodCnt + CNT_W'(1);
          end
        end
      end else begin
        // Reject: hold phase so the next window is one bit later
        state   <= ST_SEARCH;
        goodCnt <= '0;
      end
    end
  end

endmodule

// File: rtl/frame_aligner.sv
module frame_aligner
  import fal_pkg::*;
#(
  parameter int PAYLOAD_W  = 24,
  parameter int ACQ_FRAMES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pwrDnN,
  input  logic                 rxEn,
  input  logic                 serIn,
  output logic                 lockOut,
  output logic                 lockOe,
  output logic [PAYLOAD_W-1:0] dataOut,
  output logic                 dataOe,
  output logic                 wordValid
);

  localparam int FRAME_W = PAYLOAD_W + 4;

  falStrobes_t          strb;
  logic                 frameOk;
  logic                 lockFlag;
  logic                 wordStrobe;
  logic [PAYLOAD_W-1:0] wordOut;

  fal_control #(
    .FRAME_W   (FRAME_W),
    .ACQ_FRAMES(ACQ_FRAMES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pwrDnN    (pwrDnN),
    .frameOk   (frameOk),
    .strb      (strb),
    .lockFlag  (lockFlag),
    .wordStrobe(wordStrobe)
  );

  fal_datapath #(
    .PAYLOAD_W(PAYLOAD_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .serIn  (serIn),
    .strb   (strb),
    .frameOk(frameOk),
    .wordOut(wordOut)
  );

  // Enables stand in for tri-state pads
  assign lockOe    = pwrDnN;
  assign lockOut   = lockFlag & pwrDnN;
  assign dataOe    = lockFlag & rxEn & pwrDnN;
  assign dataOut   = dataOe ? wordOut : '0;
  assign wordValid = wordStrobe & dataOe;

endmodule

// File: rtl/frame_aligner_chk.sv
module frame_aligner_chk #(
  parameter int PAYLOAD_W = 24
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 pwrDnN,
  input logic                 rxEn,
  input logic                 lockOut,
  input logic                 lockOe,
  input logic [PAYLOAD_W-1:0] dataOut,
  input logic                 dataOe,
  input logic                 wordValid
);

  AST_WORD_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> lockOut) else $error("word without lock"); // R11

  AST_UNLOCKED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !lockOut |-> (dataOut == '0 && !dataOe)) else $error("data active unlocked"); // R11

  AST_RXEN_GATES: assert property (@(posedge clk) disable iff (!rstN)
    !rxEn |-> (!dataOe && !wordValid && dataOut == '0)) else $error("rxEn ignored"); // R12

  AST_PWRDN_OE: assert property (@(posedge clk) disable iff (!rstN)
    !pwrDnN |-> (!lockOe && !dataOe)) else $error("outputs on in power-down"); // R13

  AST_PWRDN_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !pwrDnN |=> !lockOut) else $error("lock survived power-down"); // R13

  AST_LOCK_WITH_WORD: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(lockOut) && rxEn) |-> wordValid) else $error("lock rose without word"); // R7

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid) else $error("strobe longer than one cycle"); // R6

endmodule

bind frame_aligner frame_aligner_chk #(.PAYLOAD_W(PAYLOAD_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .pwrDnN   (pwrDnN),
  .rxEn     (rxEn),
  .lockOut  (lockOut),
  .lockOe   (lockOe),
  .dataOut  (dataOut),
  .dataOe   (dataOe),
  .wordValid(wordValid)
);

// File: tb/frame_aligner_tb.sv
module frame_aligner_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PAY_W      = 24;
  localparam int FRM_W      = PAY_W + 4;
  localparam int ACQ        = 4;
  localparam int MAXF       = 4096;
  localparam int LOCK_WAIT  = 300 * FRM_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwrDnN = 1'b1;
  logic rxEn = 1'b1;
  logic serIn = 1'b0;
  logic lockOut, lockOe, dataOe, wordValid;
  logic [PAY_W-1:0] dataOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_aligner #(.PAYLOAD_W(PAY_W), .ACQ_FRAMES(ACQ)) u_dut (
    .clk(clk), .rstN(rstN), .pwrDnN(pwrDnN), .rxEn(rxEn), .serIn(serIn),
    .lockOut(lockOut), .lockOe(lockOe), .dataOut(dataOut),
    .dataOe(dataOe), .wordValid(wordValid)
  );

  int checks = 0;
  int errors = 0;
  logic [PAY_W-1:0] txPay [MAXF];
  int               txBad [MAXF];
  logic [FRM_W-1:0] curFrame;
  int  fi = 0;
  int  bp = 11;
  int  e1 = -1;
  int  e2 = -1;
  logic prevLock = 1'b0;
  int  corruptNext = 0;

  task automatic check(input bit cond, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R2 frame layout; bad: 1 = missing marker, 2 = parity flipped
  function automatic logic [FRM_W-1:0] buildFrame(input logic [PAY_W-1:0] p, input int bad);
    logic [FRM_W-1:0] f;
    logic [PAY_W-1:0] tx;
    logic inv;
    inv = ($countones(p) > PAY_W/2);
    tx  = inv ? ~p : p;
    f[0]         = 1'b1;
    f[PAY_W:1]   = tx;
    f[PAY_W+2]   = inv;
    f[PAY_W+1]   = ^{tx, inv};
    f[FRM_W-1]   = 1'b0;
    if (bad == 1) f[0] = 1'b0;
    if (bad == 2) f[PAY_W+1] = ~f[PAY_W+1];
    return f;
  endfunction

  function automatic logic [PAY_W-1:0] pickPayload(input int n);
    if (n % 4 == 0)   return '0;           // blocks false alignment
    if (n % 16 == 2)  return '1;           // inverted on the line
    if (n % 16 == 6)  return 24'hF0F0F0;   // balanced, sent as is
    if (n % 16 == 10) return 24'hFFFF00;   // inverted on the line
    return PAY_W'($urandom);
  endfunction

  task automatic step();
    bit ok;
    @(negedge clk);
    if (!pwrDnN) begin
      check(!lockOe && !lockOut && !dataOe && !wordValid, "R13 outputs off",
            {lockOe, lockOut, dataOe, wordValid}, 0);
    end else if (!rxEn) begin
      check(!dataOe && !wordValid && dataOut == '0, "R12 data disabled",
            {dataOe, wordValid, 6'd0, dataOut}, 0);
    end else begin
      if (!lockOut)
        check(!dataOe && !wordValid && dataOut == '0, "R11 quiet unlocked",
              {dataOe, wordValid, 6'd0, dataOut}, 0);
      if (lockOut && !prevLock)
        check(wordValid, "R7 lock with first word", wordValid, 1);
      if (wordValid) begin
        ok = (e2 >= 0) && (txBad[e2 < 0 ? 0 : e2] == 0) &&
             (dataOut == txPay[e2 < 0 ? 0 : e2]);
        check(ok, "R2 R6 word", dataOut, (e2 >= 0) ? txPay[e2] : 32'hDEAD);
        if (e2 >= 0 && $countones(txPay[e2]) > PAY_W/2)
          check(dataOut == txPay[e2], "R5 inverted word", dataOut, txPay[e2]);
      end else if (lockOut && prevLock && e2 >= 0 && txBad[e2] == 0) begin
        check(1'b0, "R6 missing word", 0, 1);
      end
      if (prevLock && e2 >= 0 && txBad[e2] != 0)
        check(!lockOut && !wordValid, (txBad[e2] == 1) ? "R8 marker loss" : "R9 parity loss",
              {lockOut, wordValid}, 0);
    end
    prevLock = lockOut;
    if (bp == 0) begin
      txPay[fi] = pickPayload(fi);
      txBad[fi] = corruptNext;
      corruptNext = 0;
      curFrame = buildFrame(txPay[fi], txBad[fi]);
    end
    serIn = curFrame[bp];
    e2 = e1;
    e1 = (bp == FRM_W-1) ? fi : -1;
    if (bp == FRM_W-1) begin
      bp = 0;
      fi++;
    end else begin
      bp++;
    end
  endtask

  task automatic runFrames(input int k);
    repeat (k * FRM_W) step();
  endtask

  task automatic waitLock(input string req);
    int n = 0;
    while (!lockOut && n < LOCK_WAIT) begin
      step();
      n++;
    end
    check(lockOut, req, lockOut, 1);
  endtask

  task automatic acqWindow(input string req);
    int early = 0;
    repeat ((ACQ-1) * FRM_W) begin
      step();
      if (lockOut) early++;
    end
    check(early == 0, req, early, 0);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    txPay[0] = '0;
    txBad[0] = 3;              // partial first frame
    curFrame = buildFrame('0, 0);
    repeat (5) @(negedge clk);
    // R1 reset state
    check(!lockOut && !dataOe && !wordValid && dataOut == '0 && lockOe,
          "R1 reset outputs", {lockOe, lockOut, dataOe, wordValid}, 32'h8);
    rstN = 1'b1;
    acqWindow("R4 no early lock");
    check(!lockOut && dataOut == '0, "R1 idle after reset", lockOut, 0);
    waitLock("R3 lock on random data");
    runFrames(30);
    corruptNext = 1;
    runFrames(3);
    check(!lockOut, "R8 lock dropped", lockOut, 0);
    waitLock("R10 relock after marker loss");
    runFrames(20);
    corruptNext = 2;
    runFrames(3);
    check(!lockOut, "R9 lock dropped", lockOut, 0);
    waitLock("R10 relock after parity loss");
    runFrames(20);
    rxEn = 1'b0;
    runFrames(3);
    check(lockOut && lockOe, "R12 lock still reported", {lockOut, lockOe}, 3);
    rxEn = 1'b1;
    runFrames(10);
    pwrDnN = 1'b0;
    runFrames(2);
    pwrDnN = 1'b1;
    acqWindow("R13 full reacquisition");
    waitLock("R13 relock after power-down");
    runFrames(20);
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not complete actual=0 expected=1");
    summary();
    $finish;
  end

endmodule